// File: doc/BRIEF.md
# MSI Source Decoder

This block takes inbound message-signalled interrupt writes and turns each one into an interrupt source number. Each write carries a 64-bit address, 16-bit data and the number of the partitionable endpoint (PE) that sent it. The source number is formed by ORing address bits [19:4] with data bits [4:0]. The block first checks that number against the configured source count, with the count limited to the number of sources the block supports. It then fetches the PE owner of that source from the vector table through a simple request/acknowledge read port. If the sender owns the source, it fires a one-cycle trigger toward the downstream pending/queued-state engine.

Software can also inject an interrupt through a forced-write input. The written value is used as the address, the data is taken as zero, and the ownership check is skipped. A lock output rises when the forced write is taken and falls once that injection has been resolved. Further forced writes are ignored while the lock is high.

Only one request is handled at a time. The inbound port is valid/ready: a write is taken on a clock edge where both are high. `msi_ready` drops while a table lookup is outstanding and while a forced injection is waiting, so the sender must hold `msi_valid` and its payload stable until a handshake occurs. The outcome pins (`trig`, `err_range`, `err_pe`, `err_read`) are plain one-cycle pulses with no back-pressure.

Top module: `msi_src_decoder`

## Requirements
- R1: The source number equals address bits [19:4] ORed with data bits [4:0]. Address bits above 19 and data bits above 4 have no effect.
- R2: A source number greater than or equal to min(`cfg_count`, MAX_SRC) is dropped. `err_range` pulses for one cycle, in the cycle after the handshake, and no table read is made.
- R3: For an in-range source, `tbl_req` rises the cycle after acceptance, with `tbl_idx` equal to the source number. Both hold steady until `tbl_ack`.
- R4: When the table read succeeds but `tbl_pe` differs from the sender's PE, the MSI is dropped and `err_pe` pulses for one cycle.
- R5: When the table read succeeds and the PE matches, `trig` pulses for exactly one cycle, in the cycle after `tbl_ack`, with `trig_src` equal to the source. At most one outcome pin is high in any cycle.
- R6: When `tbl_ack` comes with `tbl_err` high, the MSI is dropped, `err_read` pulses, and no trigger is produced.
- R7: A forced write uses `ffi_value` as the address and zero as the data, and skips the PE comparison.
- R8: `ffi_lock` rises the cycle after an accepted forced write. It falls in the same cycle as that injection's outcome pulse. A forced write presented while `ffi_lock` is high is ignored.
- R9: Requests are serialised. `msi_ready` is low while a lookup is outstanding and while a forced injection is waiting. A waiting forced injection is started before any inbound write.
- R10: After reset, `msi_ready` is high and `ffi_lock`, `tbl_req` and all outcome pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_count | input | 17 | Configured number of sources (clamped to MAX_SRC) |
| msi_valid | input | 1 | Inbound MSI write valid |
| msi_ready | output | 1 | Inbound MSI write accepted when high with valid |
| msi_addr | input | 64 | MSI write address |
| msi_data | input | 16 | MSI write data |
| msi_pe | input | PE_W | PE number of the sender |
| ffi_wr | input | 1 | Forced-interrupt register write strobe |
| ffi_value | input | 64 | Forced-interrupt written value |
| ffi_lock | output | 1 | Forced-interrupt lock |
| tbl_req | output | 1 | Vector table read request |
| tbl_idx | output | 16 | Source number to read |
| tbl_ack | input | 1 | Table read completion (one cycle) |
| tbl_err | input | 1 | Table read failed |
| tbl_pe | input | PE_W | PE owner field of the entry read |
| trig | output | 1 | One-cycle trigger for the source |
| trig_src | output | 16 | Source number of the latest outcome |
| err_range | output | 1 | Source out of range |
| err_pe | output | 1 | PE ownership mismatch |
| err_read | output | 1 | Table read failure |

## Verification
The bench builds the block with MAX_SRC = 64 and PE_W = 4. The small source limit puts the clamp in reach: with `cfg_count` at 200, source 63 passes and source 64 is dropped. With `cfg_count` at 40, the plain configured limit is tested at source 40. The bench's table model returns a 4-bit owner derived from the index after two cycles, and fails the read for source 13. Ownership matches, mismatches and read errors can therefore all be produced at chosen sources. The bench also tests a forced injection that arrives while an inbound write waits, along with a second forced write made while the lock is high.

// File: rtl/msi_dec_pkg.sv
package msi_dec_pkg;
  localparam int SRC_W = 16;
  localparam int CNT_W = SRC_W + 1;

  typedef logic [SRC_W-1:0] src_t;

  typedef enum logic {ST_IDLE, ST_LOOKUP} dec_state_e;

  function automatic src_t form_src(input logic [63:0] addr, input logic [15:0] data);
    return addr[SRC_W+3:4] | {{(SRC_W-5){1'b0}}, data[4:0]};
  endfunction
endpackage

// File: rtl/msi_src_map.sv
module msi_src_map
  import msi_dec_pkg::*;
#(
  parameter int MAX_SRC = 2048
) (
  input  logic [63:0]      addr,
  input  logic [15:0]      data,
  input  logic [CNT_W-1:0] cfg_count,
  output src_t             src,
  output logic             in_range
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_SRC);

  logic [CNT_W-1:0] eff_count;

  always_comb begin
    eff_count = (cfg_count > MAX_CNT) ? MAX_CNT : cfg_count;
    src       = form_src(addr, data);
    in_range  = {1'b0, src} < eff_count;
  end
endmodule

// File: rtl/msi_ffi_lock.sv
module msi_ffi_lock (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [63:0] value_in,
  input  logic        start,
  input  logic        done,
  output logic        pend,
  output logic        lock,
  output logic [63:0] value
);
  logic take;
  assign take = wr && !lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      lock  <= 1'b0;
      value <= '0;
    end else begin
      if (take) begin
        pend  <= 1'b1;
        lock  <= 1'b1;
        value <= value_in;
      end else begin
        if (start) pend <= 1'b0;
        if (done)  lock <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msi_lookup_fsm.sv
module msi_lookup_fsm
  import msi_dec_pkg::*;
#(
  parameter int PE_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_msi,
  input  logic            start_ffi,
  input  src_t            src,
  input  logic            in_range,
  input  logic [PE_W-1:0] pe_in,
  input  logic            tbl_ack,
  input  logic            tbl_err,
  input  logic [PE_W-1:0] tbl_pe,
  output logic            idle,
  output logic            tbl_req,
  output src_t            tbl_idx,
  output logic            trig,
  output src_t            out_src,
  output logic            err_range,
  output logic            err_pe,
  output logic            err_read,
  output logic            done_forced
);
  dec_state_e      state;
  src_t            cur_src;
  logic [PE_W-1:0] cur_pe;
  logic            cur_forced;
  logic            start;

  assign start   = start_msi || start_ffi;
  assign idle    = (state == ST_IDLE);
  assign tbl_req = (state == ST_LOOKUP);
  assign tbl_idx = cur_src;
  assign done_forced = (start_ffi && !in_range) ||
                       ((state == ST_LOOKUP) && tbl_ack && cur_forced);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_src    <= '0;
      cur_pe     <= '0;
      cur_forced <= 1'b0;
      out_src    <= '0;
      trig       <= 1'b0;
      err_range  <= 1'b0;
      err_pe     <= 1'b0;
      err_read   <= 1'b0;
    end else begin
      trig      <= 1'b0;
      err_range <= 1'b0;
      err_pe    <= 1'b0;
      err_read  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            cur_src    <= src;
            cur_pe     <= start_ffi ? '0 : pe_in;
            cur_forced <= start_ffi;
            if (!in_range) begin
              err_range <= 1'b1;
              out_src   <= src;
            end else begin
              state <= ST_LOOKUP;
            end
          end
        end
        ST_LOOKUP: begin
          if (tbl_ack) begin
            state   <= ST_IDLE;
            out_src <= cur_src;
            if (tbl_err)                               err_read <= 1'b1;
            else if (!cur_forced && tbl_pe != cur_pe)  err_pe   <= 1'b1;
            else                                       trig     <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_src_decoder.sv
module msi_src_decoder
  import msi_dec_pkg::*;
#(
  parameter int MAX_SRC = 2048,
  parameter int PE_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             msi_valid,
  output logic             msi_ready,
  input  logic [63:0]      msi_addr,
  input  logic [15:0]      msi_data,
  input  logic [PE_W-1:0]  msi_pe,
  input  logic             ffi_wr,
  input  logic [63:0]      ffi_value,
  output logic             ffi_lock,
  output logic             tbl_req,
  output logic [SRC_W-1:0] tbl_idx,
  input  logic             tbl_ack,
  input  logic             tbl_err,
  input  logic [PE_W-1:0]  tbl_pe,
  output logic             trig,
  output logic [SRC_W-1:0] trig_src,
  output logic             err_range,
  output logic             err_pe,
  output logic             err_read
);
  logic        idle, ffi_pend, start_ffi, start_msi, done_forced, in_range;
  logic [63:0] ffi_held, sel_addr;
  logic [15:0] sel_data;
  src_t        src;

  assign start_ffi = idle && ffi_pend;
  assign msi_ready = idle && !ffi_pend;
  assign start_msi = msi_valid && msi_ready;
  assign sel_addr  = start_ffi ? ffi_held : msi_addr;
  assign sel_data  = start_ffi ? 16'h0000 : msi_data;

  msi_src_map #(.MAX_SRC(MAX_SRC)) u_map (
    .addr(sel_addr), .data(sel_data), .cfg_count(cfg_count),
    .src(src), .in_range(in_range)
  );

  msi_ffi_lock u_lock (
    .clk(clk), .rst_n(rst_n), .wr(ffi_wr), .value_in(ffi_value),
    .start(start_ffi), .done(done_forced),
    .pend(ffi_pend), .lock(ffi_lock), .value(ffi_held)
  );

  msi_lookup_fsm #(.PE_W(PE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_msi(start_msi), .start_ffi(start_ffi),
    .src(src), .in_range(in_range), .pe_in(msi_pe),
    .tbl_ack(tbl_ack), .tbl_err(tbl_err), .tbl_pe(tbl_pe),
    .idle(idle), .tbl_req(tbl_req), .tbl_idx(tbl_idx),
    .trig(trig), .out_src(trig_src),
    .err_range(err_range), .err_pe(err_pe), .err_read(err_read),
    .done_forced(done_forced)
  );
endmodule

// File: rtl/msi_src_decoder_chk.sv
module msi_src_decoder_chk #(
  parameter int MAX_SRC = 2048,
  parameter int PE_W    = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        msi_ready,
  input logic        ffi_lock,
  input logic        tbl_req,
  input logic [15:0] tbl_idx,
  input logic        tbl_ack,
  input logic        tbl_err,
  input logic        trig,
  input logic [15:0] trig_src,
  input logic        err_range,
  input logic        err_pe,
  input logic        err_read
);
  // R5
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  // R5
  trig_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(tbl_req && tbl_ack && !tbl_err));
  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trig, err_range, err_pe, err_read}));
  // R6
  read_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_req && tbl_ack && tbl_err) |=> (err_read && !trig));
  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_req && !tbl_ack) |=> (tbl_req && $stable(tbl_idx)));
  // R9
  serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req |-> !msi_ready);
  // R8
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ffi_lock) |-> (trig || err_range || err_pe || err_read));
  // R2
  trig_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (32'(trig_src) < MAX_SRC));
endmodule

bind msi_src_decoder msi_src_decoder_chk #(.MAX_SRC(MAX_SRC), .PE_W(PE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_ready(msi_ready), .ffi_lock(ffi_lock),
  .tbl_req(tbl_req), .tbl_idx(tbl_idx), .tbl_ack(tbl_ack), .tbl_err(tbl_err),
  .trig(trig), .trig_src(trig_src), .err_range(err_range),
  .err_pe(err_pe), .err_read(err_read)
);

// File: tb/sim_msi_src_decoder.sv
module sim_msi_src_decoder;
  localparam int MAX_SRC = 64;
  localparam int PE_W    = 4;
  localparam int K_TRIG = 0, K_RANGE = 1, K_PE = 2, K_READ = 3;

  typedef struct {int kind; logic [15:0] src; string req;} ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [16:0] cfg_count = 17'd40;
  logic msi_valid = 1'b0;
  logic msi_ready;
  logic [63:0] msi_addr = '0;
  logic [15:0] msi_data = '0;
  logic [PE_W-1:0] msi_pe = '0;
  logic ffi_wr = 1'b0;
  logic [63:0] ffi_value = '0;
  logic ffi_lock, tbl_req;
  logic [15:0] tbl_idx;
  logic tbl_ack = 1'b0;
  logic tbl_err = 1'b0;
  logic [PE_W-1:0] tbl_pe = '0;
  logic trig, err_range, err_pe, err_read;
  logic [15:0] trig_src;

  int total = 0;
  int bad = 0;
  int dly = 0;
  ev_t expq[$];

  always #4 clk = ~clk;

  msi_src_decoder #(.MAX_SRC(MAX_SRC), .PE_W(PE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count),
    .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_addr(msi_addr),
    .msi_data(msi_data), .msi_pe(msi_pe), .ffi_wr(ffi_wr), .ffi_value(ffi_value),
    .ffi_lock(ffi_lock), .tbl_req(tbl_req), .tbl_idx(tbl_idx), .tbl_ack(tbl_ack),
    .tbl_err(tbl_err), .tbl_pe(tbl_pe), .trig(trig), .trig_src(trig_src),
    .err_range(err_range), .err_pe(err_pe), .err_read(err_read)
  );

  function automatic logic [PE_W-1:0] owner(input logic [15:0] s);
    return s[3:0] ^ 4'hA;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void expect_ev(input logic [63:0] a, input logic [15:0] d,
                                    input logic [PE_W-1:0] pe, input bit forced,
                                    input string req);
    ev_t e;
    int lim;
    e.src = a[19:4] | {11'b0, d[4:0]};
    lim = (int'(cfg_count) > MAX_SRC) ? MAX_SRC : int'(cfg_count);
    if (int'(e.src) >= lim)               e.kind = K_RANGE;
    else if (e.src == 16'd13)             e.kind = K_READ;
    else if (!forced && pe != owner(e.src)) e.kind = K_PE;
    else                                  e.kind = K_TRIG;
    e.req = req;
    expq.push_back(e);
  endfunction

  // table model: two-cycle latency, read fails for source 13
  always @(negedge clk) begin
    if (tbl_req && !tbl_ack) begin
      dly++;
      if (dly == 2) begin
        dly = 0;
        tbl_ack = 1'b1;
        tbl_err = (tbl_idx == 16'd13);
        tbl_pe  = owner(tbl_idx);
        if (expq.size() > 0) check("R3 table index", 64'(tbl_idx), 64'(expq[0].src));
      end
    end else begin
      tbl_ack = 1'b0;
      tbl_err = 1'b0;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (trig || err_range || err_pe || err_read)) begin
      int k;
      ev_t e;
      k = trig ? K_TRIG : err_range ? K_RANGE : err_pe ? K_PE : K_READ;
      if (expq.size() == 0) begin
        check("R8 unexpected outcome", 64'(k), 64'hFF);
      end else begin
        e = expq.pop_front();
        check({e.req, " kind"}, 64'(k), 64'(e.kind));
        check({e.req, " src"}, 64'(trig_src), 64'(e.src));
      end
    end
  end

  task automatic send_msi(input logic [63:0] a, input logic [15:0] d,
                          input logic [PE_W-1:0] pe, input string req);
    @(negedge clk);
    expect_ev(a, d, pe, 1'b0, req);
    msi_addr = a; msi_data = d; msi_pe = pe; msi_valid = 1'b1;
    while (!msi_ready) @(negedge clk);
    @(negedge clk);
    msi_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_ffi(input logic [63:0] v, input string req);
    @(negedge clk);
    expect_ev(v, 16'h0, '0, 1'b1, req);
    ffi_value = v; ffi_wr = 1'b1;
    @(negedge clk);
    ffi_wr = 1'b0;
    check("R8 lock raised", 64'(ffi_lock), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 ready", 64'(msi_ready), 64'd1);
    check("R10 lock", 64'(ffi_lock), 64'd0);
    check("R10 req", 64'(tbl_req), 64'd0);
    check("R10 outcomes", 64'({trig, err_range, err_pe, err_read}), 64'd0);

    // R1 address only; R5 trigger
    send_msi(64'h150, 16'h0000, owner(16'd21), "R1 R5 addr-only");
    // R1 OR with data, high data bits ignored
    send_msi(64'h200, 16'hFF07, owner(16'd39), "R1 addr|data");
    // R2 configured limit
    send_msi(64'h280, 16'h0000, owner(16'd40), "R2 at limit");
    // R4 owner mismatch
    send_msi(64'h50, 16'h0000, ~owner(16'd5), "R4 pe mismatch");
    // R6 read failure
    send_msi(64'hD0, 16'h0000, owner(16'd13), "R6 read error");
    // R2 clamp to MAX_SRC; R1 high address bits ignored
    cfg_count = 17'd200;
    send_msi(64'hFFF0_0000_0000_03F0, 16'h0000, owner(16'd63), "R1 R2 high bits");
    send_msi(64'h400, 16'h0000, owner(16'd64), "R2 clamp");

    // R7 forced, PE check skipped; R8 second write while locked ignored
    send_ffi(64'h120, "R7 forced");
    ffi_value = 64'h300; ffi_wr = 1'b1;
    @(negedge clk);
    ffi_wr = 1'b0;
    repeat (8) @(negedge clk);
    check("R8 lock released", 64'(ffi_lock), 64'd0);

    // R8 forced out of range also releases lock
    send_ffi(64'h8000, "R8 forced range");
    repeat (6) @(negedge clk);
    check("R8 lock released range", 64'(ffi_lock), 64'd0);

    // R9 forced injection takes precedence over a waiting inbound write
    @(negedge clk);
    expect_ev(64'h70, 16'h0, owner(16'd7), 1'b0, "R9 first");
    msi_addr = 64'h70; msi_data = '0; msi_pe = owner(16'd7); msi_valid = 1'b1;
    @(negedge clk);
    msi_valid = 1'b0;
    expect_ev(64'h2A0, 16'h0, '0, 1'b1, "R9 forced");
    expect_ev(64'h90, 16'h0, owner(16'd9), 1'b0, "R9 waiting");
    ffi_value = 64'h2A0; ffi_wr = 1'b1;
    msi_addr = 64'h90; msi_pe = owner(16'd9); msi_valid = 1'b1;
    @(negedge clk);
    ffi_wr = 1'b0;
    check("R9 ready low", 64'(msi_ready), 64'd0);
    while (!msi_ready) @(negedge clk);
    @(negedge clk);
    msi_valid = 1'b0;
    repeat (10) @(negedge clk);

    check("R5 all outcomes seen", 64'(expq.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule